// File: doc/BRIEF.md
# Data Address Generator with Circular and Bit-Reversed Modes

This block is the address arithmetic unit that sits beside a signal-processing datapath and produces operand addresses. It keeps four register sets. Each set holds a 24-bit pointer, a 24-bit step value and a 24-bit mode word. On every request the caller names one set and one update kind. The block puts the current pointer on its address output, works out the next pointer, and writes it back at the clock edge. That lets one pointer walk a data buffer with no extra cycles.

The mode word picks the arithmetic for the update. All ones gives plain binary counting. A small value gives a circular buffer whose length is any number up to 32768. A marked value gives power-of-two wrapping that allows strides larger than the buffer. Zero gives reverse-carry addition, which yields the bit-reversed order that FFT data shuffles need. The straight adder and the reverse-carry adder run side by side on the same operands. A third adder applies the circular-buffer correction to the straight sum.

Top module: `dsp_agu`

## Requirements
- R1: After a synchronous active-low reset, every pointer and every step register reads 0, and every mode word is all ones, which selects linear arithmetic.
- R2: When wr_en_i is high, the set named by wr_sel_i is written at the clock edge. wr_kind_i selects the target: 0 is the pointer, 1 is the step, 2 is the mode word, and 3 writes nothing. The new value is used from the next cycle on.
- R3: While req_i is high, ea_o shows the pointer of set sel_i as it was before the update, and upd_o shows the next pointer. At the clock edge the pointer takes the value of upd_o.
- R4: With mode word 0xFFFFFF, the update is modulo 2^24. The op_i codes are 0 for +1, 1 for -1, 2 for +step and 3 for -step.
- R5: With a mode word V from 0x000001 to 0x007FFF, the buffer length is M = V+1. The base is the pointer with its low ceil(log2 M) bits cleared. A move that goes above base+V lands M lower.
- R6: In the same circular mode, a move that goes below the base lands M higher. The step magnitude is assumed to be at most M.
- R7: With mode bits [23:15] = 000000001, the low 15 bits give S-1 for a power-of-two size S. The pointer keeps its bits above S-1, and its low bits take those of the straight sum, even when the step exceeds S.
- R8: With mode word 0, updates use reverse-carry arithmetic, with the carry running from bit 23 down to bit 0. The +1/-1 updates use 1 as the operand, and the step updates use the step register. A step of N/2 visits 0..N-1 in bit-reversed order and then returns to 0.
- R9: A pointer write from the write port wins over an update to the same set in the same cycle. An update and a write to different sets both take effect. With no request and no write, the pointers hold their values.
- R10: Any mode word not covered by R4, R5, R7 or R8 gives linear arithmetic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Address request; updates the selected pointer |
| sel_i | input | 2 | Register set used by the request |
| op_i | input | 2 | Update kind: 0 +1, 1 -1, 2 +step, 3 -step |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Write target: 0 pointer, 1 step, 2 mode, 3 none |
| wr_sel_i | input | 2 | Register set written |
| wr_data_i | input | 24 | Write data |
| ea_o | output | 24 | Effective address (pointer before update) |
| upd_o | output | 24 | Next pointer value |

## Verification
The case hardest to reach from the ports is a circular-buffer update that falls below the base by a full step. To get there, the pointer must first be walked to the bottom of a buffer whose length is not a power of two. The bench writes a length-10 buffer located at 0x100, steps it upward through the top wrap, then applies a -1 at the base and a -3 just above it. Each of these moves must come back inside the buffer. Reverse-carry mode is hard to reach for a similar reason: its wrap back to 0 only shows up after a full pass. The bench therefore runs an 8-point bit-reversed walk to completion, goes one step further, and compares every address with the bit-reversed index.

// File: rtl/agu_pkg.sv
// Package: shared encodings for the data address generator.
// Assumes a 24-bit address space and four register sets by default.
package agu_pkg;

    localparam int AGU_AW    = 24;
    localparam int AGU_NSET  = 4;
    localparam int AGU_FLDW  = 15;

    // update kinds carried on op_i
    typedef enum logic [1:0] {
        UPD_INC = 2'd0,
        UPD_DEC = 2'd1,
        UPD_ADD = 2'd2,
        UPD_SUB = 2'd3
    } upd_op_e;

    // write targets carried on wr_kind_i
    typedef enum logic [1:0] {
        WR_PTR  = 2'd0,
        WR_STEP = 2'd1,
        WR_MODE = 2'd2,
        WR_NONE = 2'd3
    } wr_kind_e;

    // arithmetic kinds decoded from the mode word
    typedef enum logic [1:0] {
        AM_LIN  = 2'd0,
        AM_CIRC = 2'd1,
        AM_WRAP = 2'd2,
        AM_REV  = 2'd3
    } amode_e;

endpackage

// File: rtl/agu_regfile.sv
// Register sets: pointer, step and mode word for each set.
// Pointer writes from the write port take priority over request updates.
// Assumes wr_sel and upd_sel index inside NSET.
module agu_regfile #(
    parameter int AW   = 24,
    parameter int NSET = 4,
    localparam int SW  = (NSET > 1) ? $clog2(NSET) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               wr_kind,
    input  logic [SW-1:0]            wr_sel,
    input  logic [AW-1:0]            wr_data,
    input  logic                     upd_en,
    input  logic [SW-1:0]            upd_sel,
    input  logic [AW-1:0]            upd_val,
    output logic [NSET-1:0][AW-1:0]  ptr_q,
    output logic [NSET-1:0][AW-1:0]  step_q,
    output logic [NSET-1:0][AW-1:0]  mode_q
);
    import agu_pkg::*;

    // Purpose: reset, write and update all register sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSET; s++) begin
                ptr_q[s]  <= '0;
                step_q[s] <= '0;
                mode_q[s] <= '1;
            end
        end else begin
            for (int s = 0; s < NSET; s++) begin
                if (wr_en && (wr_sel == SW'(s)) && (wr_kind == WR_PTR))
                    ptr_q[s] <= wr_data;
                else if (upd_en && (upd_sel == SW'(s)))
                    ptr_q[s] <= upd_val;
                if (wr_en && (wr_sel == SW'(s)) && (wr_kind == WR_STEP))
                    step_q[s] <= wr_data;
                if (wr_en && (wr_sel == SW'(s)) && (wr_kind == WR_MODE))
                    mode_q[s] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/agu_mode_decode.sv
// Mode-word decoder: selects the arithmetic kind, the buffer mask
// (all ones below the top set bit of the length field) and length-1.
// Assumes the wrap field holds a power of two minus one.
module agu_mode_decode #(
    parameter int AW   = 24,
    parameter int FLDW = 15
) (
    input  logic [AW-1:0]     mode_word,
    output agu_pkg::amode_e   amode,
    output logic [AW-1:0]     mask,
    output logic [AW-1:0]     lenm1
);
    import agu_pkg::*;

    logic [FLDW-1:0] fld;
    logic [FLDW-1:0] smear;
    logic [AW-FLDW-1:0] hi;

    assign fld = mode_word[FLDW-1:0];
    assign hi  = mode_word[AW-1:FLDW];

    // Purpose: classify the mode word into an arithmetic kind.
    always_comb begin
        if (&mode_word)
            amode = AM_LIN;
        else if (mode_word == '0)
            amode = AM_REV;
        else if (hi == '0)
            amode = AM_CIRC;
        else if (hi == (AW-FLDW)'(1))
            amode = AM_WRAP;
        else
            amode = AM_LIN;
    end

    // Purpose: fill ones below the highest set bit of the length field.
    always_comb begin
        smear[FLDW-1] = fld[FLDW-1];
        for (int i = FLDW - 2; i >= 0; i--)
            smear[i] = smear[i+1] | fld[i];
    end

    assign mask  = {{(AW-FLDW){1'b0}}, smear};
    assign lenm1 = {{(AW-FLDW){1'b0}}, fld};

endmodule

// File: rtl/agu_addr_alu.sv
// Address arithmetic: a straight offset adder and a reverse-carry adder
// working in parallel on the same operands, plus a correction adder for
// circular buffers. Pure combinational; result chosen by the mode.
// Assumes circular-buffer step magnitude at most the buffer length.
module agu_addr_alu #(
    parameter int AW = 24
) (
    input  logic [AW-1:0]    ptr,
    input  logic [AW-1:0]    step,
    input  logic [1:0]       op,
    input  agu_pkg::amode_e  amode,
    input  logic [AW-1:0]    mask,
    input  logic [AW-1:0]    lenm1,
    output logic [AW-1:0]    nxt
);
    import agu_pkg::*;

    localparam int WW = AW + 2;

    logic signed [WW-1:0] delta;
    logic signed [WW-1:0] sum_w;
    logic signed [WW-1:0] base_w;
    logic signed [WW-1:0] top_w;
    logic signed [WW-1:0] len_w;
    logic signed [WW-1:0] circ_w;
    logic [AW-1:0] lin_sum;
    logic [AW-1:0] base;
    logic [AW-1:0] wrap_res;
    logic [AW-1:0] rev_opnd;
    logic [AW-1:0] rev_a;
    logic [AW-1:0] rev_b;
    logic [AW-1:0] rev_sum;
    logic [AW-1:0] rev_res;
    logic          rev_sub;
    logic          moving_up;
    logic          over_top;
    logic          under_base;
    logic          unused_hi;

    // Purpose: form the signed step for the requested update kind.
    always_comb begin
        case (op)
            UPD_INC: delta = WW'(1);
            UPD_DEC: delta = '1;
            UPD_ADD: delta = {{2{step[AW-1]}}, step};
            default: delta = -{{2{step[AW-1]}}, step};
        endcase
    end

    // offset adder, straight carry
    assign lin_sum = ptr + delta[AW-1:0];
    assign sum_w   = signed'({2'b00, ptr}) + delta;

    // circular buffer bounds and correction adder
    assign base       = ptr & ~mask;
    assign base_w     = signed'({2'b00, base});
    assign top_w      = base_w + signed'({2'b00, lenm1});
    assign len_w      = signed'({2'b00, lenm1}) + WW'(1);
    assign moving_up  = ~delta[WW-1];
    assign over_top   = moving_up && (sum_w > top_w);
    assign under_base = !moving_up && (sum_w < base_w);

    // Purpose: apply the length correction when the sum leaves the buffer.
    always_comb begin
        if (over_top)
            circ_w = sum_w - len_w;
        else if (under_base)
            circ_w = sum_w + len_w;
        else
            circ_w = sum_w;
    end

    assign unused_hi = ^circ_w[WW-1:AW];

    // power-of-two wrap keeps the high part of the pointer
    assign wrap_res = (ptr & ~mask) | (lin_sum & mask);

    // reverse-carry adder operands
    assign rev_opnd = (op == UPD_INC || op == UPD_DEC) ? AW'(1) : step;
    assign rev_sub  = (op == UPD_DEC || op == UPD_SUB);

    // Purpose: mirror operands so an ordinary adder carries MSB to LSB.
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            rev_a[i] = ptr[AW-1-i];
            rev_b[i] = rev_opnd[AW-1-i];
        end
    end

    assign rev_sum = rev_sub ? (rev_a - rev_b) : (rev_a + rev_b);

    // Purpose: mirror the reverse-carry sum back to address order.
    always_comb begin
        for (int i = 0; i < AW; i++)
            rev_res[i] = rev_sum[AW-1-i];
    end

    // Purpose: pick the result of the arithmetic kind in force.
    always_comb begin
        case (amode)
            AM_CIRC: nxt = circ_w[AW-1:0];
            AM_WRAP: nxt = wrap_res;
            AM_REV:  nxt = rev_res;
            default: nxt = lin_sum;
        endcase
    end

endmodule

// File: rtl/dsp_agu.sv
// Top of the data address generator. ea_o is the selected pointer
// before update; upd_o is its next value, committed at the edge when
// req_i is high. Assumes requests and writes are driven synchronously.
module dsp_agu #(
    parameter int AW   = agu_pkg::AGU_AW,
    parameter int NSET = agu_pkg::AGU_NSET,
    parameter int FLDW = agu_pkg::AGU_FLDW,
    localparam int SW  = (NSET > 1) ? $clog2(NSET) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_i,
    input  logic [SW-1:0]  sel_i,
    input  logic [1:0]     op_i,
    input  logic           wr_en_i,
    input  logic [1:0]     wr_kind_i,
    input  logic [SW-1:0]  wr_sel_i,
    input  logic [AW-1:0]  wr_data_i,
    output logic [AW-1:0]  ea_o,
    output logic [AW-1:0]  upd_o
);
    import agu_pkg::*;

    logic [NSET-1:0][AW-1:0] ptr_q;
    logic [NSET-1:0][AW-1:0] step_q;
    logic [NSET-1:0][AW-1:0] mode_q;
    logic [AW-1:0]           mode_sel;
    logic [AW-1:0]           mask;
    logic [AW-1:0]           lenm1;
    amode_e                  amode;

    agu_regfile #(.AW(AW), .NSET(NSET)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_kind (wr_kind_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .upd_en  (req_i),
        .upd_sel (sel_i),
        .upd_val (upd_o),
        .ptr_q   (ptr_q),
        .step_q  (step_q),
        .mode_q  (mode_q)
    );

    assign mode_sel = mode_q[sel_i];

    agu_mode_decode #(.AW(AW), .FLDW(FLDW)) u_dec (
        .mode_word (mode_sel),
        .amode     (amode),
        .mask      (mask),
        .lenm1     (lenm1)
    );

    agu_addr_alu #(.AW(AW)) u_alu (
        .ptr   (ptr_q[sel_i]),
        .step  (step_q[sel_i]),
        .op    (op_i),
        .amode (amode),
        .mask  (mask),
        .lenm1 (lenm1),
        .nxt   (upd_o)
    );

    assign ea_o = ptr_q[sel_i];

endmodule

// File: rtl/dsp_agu_chk.sv
// Checker for dsp_agu: relates requests, writes and the stored pointers.
// Assumes the default mode-field width split of the top module.
module dsp_agu_chk #(
    parameter int AW   = 24,
    parameter int NSET = 4,
    parameter int FLDW = 15,
    localparam int SW  = (NSET > 1) ? $clog2(NSET) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [SW-1:0]           sel_i,
    input  logic [1:0]              op_i,
    input  logic                    wr_en_i,
    input  logic [1:0]              wr_kind_i,
    input  logic [SW-1:0]           wr_sel_i,
    input  logic [AW-1:0]           wr_data_i,
    input  logic [AW-1:0]           ea_o,
    input  logic [AW-1:0]           upd_o,
    input  logic [NSET-1:0][AW-1:0] ptr_q,
    input  logic [AW-1:0]           mode_sel
);
    logic          ptr_wr;
    logic          clash;
    logic [AW-1:0] fmask;

    assign ptr_wr = wr_en_i && (wr_kind_i == 2'd0);
    assign clash  = ptr_wr && (wr_sel_i == sel_i);
    assign fmask  = {{(AW-FLDW){1'b0}}, mode_sel[FLDW-1:0]};

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ptr_q == '0));

    // R2
    ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (ptr_q[$past(wr_sel_i)] == $past(wr_data_i)));

    // R3
    upd_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !clash) |=> (ptr_q[$past(sel_i)] == $past(upd_o)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !wr_en_i) |=> $stable(ptr_q));

    // R4
    lin_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (&mode_sel) && op_i == 2'd0) |-> (upd_o == ea_o + AW'(1)));

    // R7
    wrap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_sel[AW-1:FLDW] == (AW-FLDW)'(1))
            |-> (((upd_o ^ ea_o) & ~fmask) == '0));

endmodule

bind dsp_agu dsp_agu_chk #(.AW(AW), .NSET(NSET), .FLDW(FLDW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .sel_i     (sel_i),
    .op_i      (op_i),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ea_o      (ea_o),
    .upd_o     (upd_o),
    .ptr_q     (ptr_q),
    .mode_sel  (mode_sel)
);

// File: tb/dsp_agu_tb.sv
`timescale 1ns/1ps
// Directed bench for dsp_agu: one task per scenario, each self-checking.
module dsp_agu_tb;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [1:0]    sel_i = '0;
    logic [1:0]    op_i = '0;
    logic          wr_en_i = 1'b0;
    logic [1:0]    wr_kind_i = '0;
    logic [1:0]    wr_sel_i = '0;
    logic [AW-1:0] wr_data_i = '0;
    logic [AW-1:0] ea_o;
    logic [AW-1:0] upd_o;

    int checks = 0;
    int errors = 0;

    dsp_agu u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_i(sel_i), .op_i(op_i),
        .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .ea_o(ea_o), .upd_o(upd_o)
    );

    // 200 MHz
    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] kind, input logic [1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_kind_i = kind; wr_sel_i = s; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // one request: check both outputs before the edge, commit at the edge
    task automatic req(input string tag, input logic [1:0] s, input logic [1:0] op,
                       input logic [AW-1:0] exp_ea, input logic [AW-1:0] exp_upd);
        @(negedge clk);
        req_i = 1'b1; sel_i = s; op_i = op;
        #1;
        check({tag, " ea"}, ea_o, exp_ea);
        check({tag, " upd"}, upd_o, exp_upd);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic peek(input string tag, input logic [1:0] s, input logic [AW-1:0] exp_ea);
        @(negedge clk);
        sel_i = s;
        #1;
        check(tag, ea_o, exp_ea);
    endtask

    task automatic t_reset();
        for (int s = 0; s < 4; s++) begin
            req("R1 reset inc", 2'(s), 2'd0, 24'h0, 24'h1);
            req("R1 reset step zero", 2'(s), 2'd2, 24'h1, 24'h1);
        end
    endtask

    task automatic t_linear();
        wr(2'd0, 2'd1, 24'hFFFFFF);
        wr(2'd1, 2'd1, 24'h000010);
        req("R4 inc wrap", 2'd1, 2'd0, 24'hFFFFFF, 24'h000000);
        req("R4 dec wrap", 2'd1, 2'd1, 24'h000000, 24'hFFFFFF);
        wr(2'd0, 2'd1, 24'hFFFFF8);
        req("R4 add step", 2'd1, 2'd2, 24'hFFFFF8, 24'h000008);
        req("R4 sub step", 2'd1, 2'd3, 24'h000008, 24'hFFFFF8);
        // R2 kind 3 writes nothing: pointer, step, mode unchanged
        wr(2'd3, 2'd1, 24'h000000);
        req("R2 kind3 ignored", 2'd1, 2'd2, 24'hFFFFF8, 24'h000008);
        // R10 unknown mode word behaves as linear
        wr(2'd2, 2'd1, 24'h010000);
        wr(2'd0, 2'd1, 24'h007FFF);
        req("R10 other mode linear", 2'd1, 2'd0, 24'h007FFF, 24'h008000);
    endtask

    task automatic t_circular();
        wr(2'd2, 2'd0, 24'h000009);
        wr(2'd1, 2'd0, 24'h000003);
        wr(2'd0, 2'd0, 24'h000107);
        req("R5 inc in buf", 2'd0, 2'd0, 24'h107, 24'h108);
        req("R5 inc to top", 2'd0, 2'd0, 24'h108, 24'h109);
        req("R5 inc wrap", 2'd0, 2'd0, 24'h109, 24'h100);
        req("R6 dec wrap", 2'd0, 2'd1, 24'h100, 24'h109);
        req("R5 add wrap", 2'd0, 2'd2, 24'h109, 24'h102);
        req("R6 sub wrap", 2'd0, 2'd3, 24'h102, 24'h109);
        req("R6 dec in buf", 2'd0, 2'd1, 24'h109, 24'h108);
    endtask

    task automatic t_multiwrap();
        wr(2'd2, 2'd3, 24'h00800F);
        wr(2'd1, 2'd3, 24'h000025);
        wr(2'd0, 2'd3, 24'h00020C);
        req("R7 big step add", 2'd3, 2'd2, 24'h20C, 24'h201);
        req("R7 big step sub", 2'd3, 2'd3, 24'h201, 24'h20C);
        req("R7 inc", 2'd3, 2'd0, 24'h20C, 24'h20D);
    endtask

    task automatic t_bitrev();
        logic [AW-1:0] exp_cur;
        logic [AW-1:0] exp_nxt;
        wr(2'd2, 2'd2, 24'h000000);
        wr(2'd1, 2'd2, 24'h000004);
        wr(2'd0, 2'd2, 24'h000000);
        for (int i = 0; i < 8; i++) begin
            exp_cur = {21'd0, i[0], i[1], i[2]};
            exp_nxt = (i == 7) ? 24'h0 : {21'd0, 3'({i[0], i[1], i[2]} == 3'd0 ? 3'd0 : 3'd0)};
            exp_nxt = {21'd0, 3'(((i + 1) & 1) << 2 | ((i + 1) & 2) | ((i + 1) & 4) >> 2)};
            if (i == 7) exp_nxt = 24'h0;
            req("R8 fft order", 2'd2, 2'd2, exp_cur, exp_nxt);
        end
        // reverse-carry -1 from 0: mirrored borrow lands on bit 0
        req("R8 rev dec", 2'd2, 2'd1, 24'h000000, 24'h000001);
    endtask

    task automatic t_collide();
        wr(2'd2, 2'd0, 24'hFFFFFF);
        wr(2'd0, 2'd0, 24'h000050);
        // same set: write wins
        @(negedge clk);
        req_i = 1'b1; sel_i = 2'd0; op_i = 2'd0;
        wr_en_i = 1'b1; wr_kind_i = 2'd0; wr_sel_i = 2'd0; wr_data_i = 24'h000077;
        @(negedge clk);
        req_i = 1'b0; wr_en_i = 1'b0;
        peek("R9 write wins", 2'd0, 24'h000077);
        // different sets: both happen
        @(negedge clk);
        req_i = 1'b1; sel_i = 2'd0; op_i = 2'd0;
        wr_en_i = 1'b1; wr_kind_i = 2'd0; wr_sel_i = 2'd1; wr_data_i = 24'h000033;
        @(negedge clk);
        req_i = 1'b0; wr_en_i = 1'b0;
        peek("R9 update other set", 2'd0, 24'h000078);
        peek("R9 write other set", 2'd1, 24'h000033);
        repeat (3) @(negedge clk);
        peek("R9 idle hold", 2'd0, 24'h000078);
        // R3 ea shows old value while request active, pointer commits
        req("R3 pre-update ea", 2'd0, 2'd1, 24'h000078, 24'h000077);
        peek("R3 committed", 2'd0, 24'h000077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_linear();
        t_circular();
        t_multiwrap();
        t_bitrev();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule